// File: doc/BRIEF.md
# Multiphase Hybrid PWM Generator

This block produces a single pulse-width-modulated output whose on-time is set with a resolution of a quarter of the main clock period, without running any logic faster than that clock. A coarse up-counter on the 0-degree clock divides the time into periods of 2^(DUTY_W-2) cycles. A shadow copy of the duty command is taken each time the counter wraps. Its upper field picks the whole-cycle part of the on-time and its two low bits pick the quarter-cycle part.

The falling edge is placed by a short chain of capture flops. Each flop runs on one of four copies of the clock, shifted by 0, 90, 180 and 270 degrees, and each holds the end-of-pulse decode one quarter later than the flop before it. The low duty bits pick which copy ends the pulse. The whole reset path is therefore made of flops and a small gate, and no asynchronous clear is formed from routing delays. The four clocks are primary inputs, all at one frequency with a fixed quarter-period skew.

The output stage is a two-state machine. LATCH_OFF moves to LATCH_ON through the ARM transition when the set decode fires (counter at zero, upper duty field non-zero). LATCH_ON returns to LATCH_OFF through the RELEASE transition when the stage-0 capture flop holds the clear decode and no set is pending. LATCH_ON stays in LATCH_ON through the REARM transition when the set and the stage-0 capture coincide. The pin is high in LATCH_ON unless the selected phase copy of the clear is active, so a clear always wins over a held set.

Top module: `dpwm_multiphase`

## Requirements
- R1: While `rst` is high, `pwm_out` is 0. Reset puts the counter at its all-ones value and the shadow duty at zero.
- R2: The period is 2^(DUTY_W-2) cycles of `clk_phase[0]`. With a non-zero upper field, `pwm_out` rises exactly once per period, at the `clk_phase[0]` rising edge that ends the cycle in which the counter is zero.
- R3: Let U = duty[DUTY_W-1:2] and L = duty[1:0]. For U != 0, `pwm_out` stays high for 4*U + L quarter periods of the clock. With DUTY_W = 5 and a duty of 01001 (binary), that is 9 quarters, or two cycles and one quarter.
- R4: When U = 0, `pwm_out` stays low for the whole period, whatever the value of L.
- R5: When U is at its maximum, the clear still lands inside the period: the output is high for 4*U + L quarters and low for 4 - L quarters. The set of the following period is not lost, and while the selected clear copy is active the output is low even if a set is pending.
- R6: The duty command is sampled only when the counter wraps to zero. A change in the middle of a period takes effect from the next period, and the current pulse keeps its width.
- R7: The duty applied before reset is released is used for the first period. The first rising edge of `pwm_out` comes at the second `clk_phase[0]` rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_phase | input | 2**FINE_W (4) | Phase clocks: bit k lags bit 0 by k quarter periods; bit 0 runs the counter |
| rst | input | 1 | Active-high asynchronous reset |
| duty_cmd | input | DUTY_W | Duty command: upper bits give whole cycles, low FINE_W bits give quarter cycles |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with DUTY_W = 5 and FINE_W = 2. This gives an 8-cycle period and only 32 duty codes, so every code is swept and its on-time is counted in quarter-period samples. The sweep covers the suppressed codes with U = 0, the worked 01001 case, and the codes with U at its maximum, where the clear lands in the first cycle of the next period. The same build makes a mid-period duty change and the first period after reset cheap to align and observe.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/100ps
package dpwm_pkg;

    // Output stage: the pin may only be high while armed.
    typedef enum logic {
        LATCH_OFF = 1'b0,
        LATCH_ON  = 1'b1
    } latch_state_e;

endpackage

// File: rtl/dpwm_coarse.sv
`timescale 1ns/100ps
// Coarse period counter, shadow duty register and set/clear decode.
module dpwm_coarse #(
    parameter int DUTY_W = 5,
    parameter int FINE_W = 2,
    localparam int CNT_W = DUTY_W - FINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_cmd,
    output logic [CNT_W-1:0]  cnt,
    output logic [DUTY_W-1:0] shadow,
    output logic [FINE_W-1:0] fine_sel,
    output logic              set_dec,
    output logic              clr_dec
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] coarse_hi;

    // Reset to all ones so the first edge after release loads the shadow.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt    <= CNT_MAX;
            shadow <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_MAX) begin
                shadow <= duty_cmd;
            end
        end
    end

    always_comb begin
        coarse_hi = shadow[DUTY_W-1:FINE_W];
        fine_sel  = shadow[FINE_W-1:0];
        set_dec   = (cnt == '0) && (coarse_hi != '0);
        clr_dec   = (cnt == coarse_hi);
    end

endmodule

// File: rtl/dpwm_phase_chain.sv
`timescale 1ns/100ps
// Clear-decode capture chain across the phase clocks and fine-select mux.
module dpwm_phase_chain #(
    parameter int FINE_W = 2,
    localparam int PHASES = 2 ** FINE_W
) (
    input  logic [PHASES-1:0] clk_phase,
    input  logic              rst,
    input  logic              clr_dec,
    input  logic [FINE_W-1:0] sel_in,
    output logic              cap0,
    output logic              clr_active
);
    logic [PHASES-1:0] tap;
    logic [FINE_W-1:0] sel_q;

    for (genvar k = 0; k < PHASES; k++) begin : g_stage
        logic q;
        if (k == 0) begin : g_first
            always_ff @(posedge clk_phase[0] or posedge rst) begin
                if (rst) q <= 1'b0;
                else     q <= clr_dec;
            end
        end else begin : g_next
            always_ff @(posedge clk_phase[k] or posedge rst) begin
                if (rst) q <= 1'b0;
                else     q <= tap[k-1];
            end
        end
        assign tap[k] = q;
    end

    // The select travels with the pulse, so a shadow reload that happens
    // while a late clear is still in flight cannot retarget it.
    always_ff @(posedge clk_phase[0] or posedge rst) begin
        if (rst) begin
            sel_q <= '0;
        end else if (clr_dec) begin
            sel_q <= sel_in;
        end
    end

    assign cap0       = tap[0];
    assign clr_active = tap[0] & tap[sel_q];

endmodule

// File: rtl/dpwm_out_latch.sv
`timescale 1ns/100ps
// Set/clear output stage as a two-state machine on the 0-degree clock.
module dpwm_out_latch
    import dpwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_dec,
    input  logic cap0,
    input  logic clr_active,
    output logic armed,
    output logic pwm
);
    latch_state_e state, state_nx;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= LATCH_OFF;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LATCH_OFF: if (set_dec) state_nx = LATCH_ON;            // ARM
            LATCH_ON:  if (cap0 && !set_dec) state_nx = LATCH_OFF;  // RELEASE, else REARM
        endcase
    end

    always_comb begin
        armed = (state == LATCH_ON);
        pwm   = armed && !clr_active;
    end

endmodule

// File: rtl/dpwm_multiphase.sv
`timescale 1ns/100ps
// Hybrid coarse/fine PWM generator, quarter-period resolution.
module dpwm_multiphase #(
    parameter int DUTY_W = 5,
    parameter int FINE_W = 2,
    localparam int PHASES = 2 ** FINE_W,
    localparam int CNT_W  = DUTY_W - FINE_W
) (
    input  logic [PHASES-1:0] clk_phase,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_cmd,
    output logic              pwm_out
);
    logic [CNT_W-1:0]  cnt_w;
    logic [DUTY_W-1:0] shadow_w;
    logic [FINE_W-1:0] fine_w;
    logic              set_dec_w;
    logic              clr_dec_w;
    logic              cap0_w;
    logic              clr_active_w;
    logic              armed_w;

    dpwm_coarse #(.DUTY_W(DUTY_W), .FINE_W(FINE_W)) u_coarse (
        .clk      (clk_phase[0]),
        .rst      (rst),
        .duty_cmd (duty_cmd),
        .cnt      (cnt_w),
        .shadow   (shadow_w),
        .fine_sel (fine_w),
        .set_dec  (set_dec_w),
        .clr_dec  (clr_dec_w)
    );

    dpwm_phase_chain #(.FINE_W(FINE_W)) u_chain (
        .clk_phase  (clk_phase),
        .rst        (rst),
        .clr_dec    (clr_dec_w),
        .sel_in     (fine_w),
        .cap0       (cap0_w),
        .clr_active (clr_active_w)
    );

    dpwm_out_latch u_latch (
        .clk        (clk_phase[0]),
        .rst        (rst),
        .set_dec    (set_dec_w),
        .cap0       (cap0_w),
        .clr_active (clr_active_w),
        .armed      (armed_w),
        .pwm        (pwm_out)
    );

endmodule

// File: rtl/dpwm_multiphase_chk.sv
`timescale 1ns/100ps
// Property checker, bound into every instance of the top module.
module dpwm_multiphase_chk #(
    parameter int DUTY_W = 5,
    parameter int FINE_W = 2,
    localparam int CNT_W = DUTY_W - FINE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              pwm_out,
    input logic [CNT_W-1:0]  cnt,
    input logic [DUTY_W-1:0] shadow,
    input logic              set_dec,
    input logic              cap0,
    input logic              armed
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always @(posedge clk) begin
        if (rst) begin
            AST_RESET_LOW: assert (!pwm_out) else $error("pwm high in reset"); // R1
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2

    AST_ARM_ON_SET: assert property (@(posedge clk) disable iff (rst)
        set_dec |=> armed); // R2

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (armed && cap0 && !set_dec) |=> !armed); // R3

    AST_ZERO_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        (shadow[DUTY_W-1:FINE_W] == '0 && cnt != '0) |-> !pwm_out); // R4

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt != CNT_MAX) |=> $stable(shadow)); // R6

endmodule

bind dpwm_multiphase dpwm_multiphase_chk #(.DUTY_W(DUTY_W), .FINE_W(FINE_W)) u_chk (
    .clk     (clk_phase[0]),
    .rst     (rst),
    .pwm_out (pwm_out),
    .cnt     (cnt_w),
    .shadow  (shadow_w),
    .set_dec (set_dec_w),
    .cap0    (cap0_w),
    .armed   (armed_w)
);

// File: tb/dpwm_multiphase_test.sv
`timescale 1ns/100ps
module dpwm_multiphase_test;
    localparam int DUTY_W = 5;
    localparam int FINE_W = 2;
    localparam int NCYC   = 2 ** (DUTY_W - FINE_W);
    localparam int QPER   = 4 * NCYC;

    logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
    logic [3:0] clk_phase;
    logic rst;
    logic [DUTY_W-1:0] duty;
    logic pwm;
    int n_checks = 0;
    int n_fail = 0;

    assign clk_phase = {c3, c2, c1, c0};

    // 50 MHz, 20 ns period; quarter skew of 5 ns between phases.
    initial forever #10 c0 = ~c0;
    initial begin #5;  forever #10 c1 = ~c1; end
    initial begin #10; forever #10 c2 = ~c2; end
    initial begin #15; forever #10 c3 = ~c3; end

    dpwm_multiphase #(.DUTY_W(DUTY_W), .FINE_W(FINE_W)) uut (
        .clk_phase (clk_phase),
        .rst       (rst),
        .duty_cmd  (duty),
        .pwm_out   (pwm)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Move to 2.5 ns after a 0-degree rising edge: mid-quarter, off all edges.
    task automatic align();
        @(posedge c0);
        #2.5;
    endtask

    // Sample n consecutive quarters; leaves the time at the next sample point.
    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm) highs++;
            #5;
        end
    endtask

    task automatic test_reset_hold();   // R1
        int h;
        rst = 1'b1;
        duty = 5'd31;
        #3;
        check("R1 pwm during reset", int'(pwm), 0);
        align();
        count_high(QPER, h);
        check("R1 high quarters in reset", h, 0);
    endtask

    task automatic test_first_period();  // R7, worked example of R3
        int h;
        duty = 5'b01001;
        align();
        rst = 1'b0;
        @(posedge c0); #2.5;
        check("R7 pwm after first edge", int'(pwm), 0);
        @(posedge c0); #2.5;
        check("R7 pwm after second edge", int'(pwm), 1);
        count_high(QPER, h);
        check("R3 example 01001 high quarters", h, 9);
    endtask

    task automatic test_sweep();  // R3 R4 R5
        int h;
        align();
        for (int dc = 0; dc < 32; dc++) begin
            duty = DUTY_W'(dc);
            #(2 * NCYC * 20);
            count_high(QPER, h);
            if (dc < 4)        check($sformatf("R4 dc=%0d high quarters", dc), h, 0);
            else if (dc >= 28) check($sformatf("R5 dc=%0d high quarters", dc), h, dc);
            else               check($sformatf("R3 dc=%0d high quarters", dc), h, dc);
            if (dc >= 28) check($sformatf("R5 dc=%0d low quarters", dc), QPER - h, QPER - dc);
        end
    endtask

    task automatic test_period();  // R2
        int rises;
        logic prev;
        duty = 5'd12;
        align();
        #(2 * NCYC * 20);
        prev = pwm;
        #5;
        rises = 0;
        for (int i = 0; i < 2 * QPER; i++) begin
            if (pwm && !prev) rises++;
            prev = pwm;
            #5;
        end
        check("R2 rises in two periods", rises, 2);
    endtask

    task automatic test_midchange();  // R6
        int h;
        logic prev;
        bit found;
        duty = 5'd20;
        align();
        #(2 * NCYC * 20);
        prev = pwm;
        found = 1'b0;
        for (int i = 0; i < 3 * NCYC && !found; i++) begin
            @(posedge c0); #2.5;
            if (pwm && !prev) found = 1'b1;
            prev = pwm;
        end
        check("R6 period start found", int'(found), 1);
        h = 0;
        for (int i = 0; i < QPER; i++) begin
            if (i == 8) duty = 5'd8;
            if (pwm) h++;
            #5;
        end
        check("R6 current period keeps width", h, 20);
        count_high(QPER, h);
        check("R6 next period uses new duty", h, 8);
    endtask

    initial begin
        test_reset_hold();
        test_first_period();
        test_sweep();
        test_period();
        test_midchange();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1ms;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule